// File: doc/BRIEF.md
# Multi-Source Result Collector with Forwarding Slot

This block merges completion results from several functional units onto one result stream, which feeds a single announcement consumer. Each source offers a result record through a valid/ready handshake. The record carries a reorder-buffer tag, a destination register id, the computed value and an exception flag. The output stream carries one record per transfer, and the record passes through unchanged.

A single-entry forwarding slot sits on the output data path. When two sources hold results in the same cycle, both are taken. One goes straight to the consumer, and the other is parked in the slot and emerges in the next cycle. The losing unit is therefore released at once and can start its next instruction instead of stalling. If the consumer is not ready, the record it was offered is parked, so the output holds stable.

Back-pressure rules:
- A source holds its valid and its record steady until it sees ready.
- The collector raises a source's ready only toward a valid source, and at most once per transfer.
- The consumer takes a record on any cycle where out_valid and out_ready are both high.
- While the slot is full, it is drained before any source is granted.
- The consumer's ready gates only the parking of a second result. A single grant depends on the slot state and the arbiter alone.

Priority among valid sources rotates round-robin, starting at source 0 after reset.

Top module: `result_collector`

## Requirements
- R1: After reset the forwarding slot is empty: with no source valid, out_valid is 0 and every src_ready bit is 0.
- R2: out_valid is 1 exactly when the slot is full or at least one source is valid.
- R3: The rob id, destination, value and exception fields reach the output unchanged.
- R4: With the slot empty and one valid source, that source is granted in the same cycle and its record is shown on the output in that cycle.
- R5: With the slot empty, out_ready high and two or more valid sources, two sources are granted. The first in rotation order goes out directly. The second is parked and is shown on the output in the following cycle.
- R6: While the slot is full, no source is granted and the output shows the parked record.
- R7: When out_valid is high and out_ready low, at most one source is granted and the output record stays unchanged in the next cycle.
- R8: Priority is round-robin. After a cycle with grants, the search starts at the source after the last one granted (index wraps from NUM_SRC-1 to 0). Source 0 leads after reset.
- R9: src_ready is raised only toward a valid source, and never toward more than two sources in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | NUM_SRC | Per-source result valid |
| src_ready | output | NUM_SRC | Per-source grant; a transfer when paired with valid |
| src_rob_id | input | NUM_SRC x RC_ROB_W | Per-source reorder-buffer tag |
| src_rp_dst | input | NUM_SRC x RC_REG_W | Per-source destination register id |
| src_value | input | NUM_SRC x RC_VAL_W | Per-source result value |
| src_exception | input | NUM_SRC | Per-source exception flag |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Consumer ready |
| out_rob_id | output | RC_ROB_W | Output reorder-buffer tag |
| out_rp_dst | output | RC_REG_W | Output destination register id |
| out_value | output | RC_VAL_W | Output result value |
| out_exception | output | 1 | Output exception flag |

## Verification
A slot whose full flag is wrong shows up in the same cycle. If the slot is wrongly marked empty, a record is dropped: the parked result never appears in the cycle after a double grant. If it is wrongly marked full, a stale record appears, or a source is refused while out_valid should reflect only fresh sources. A wrong rotation pointer shows up as a grant pattern that differs from the expected one at the very next multi-source cycle. The directed scenarios therefore compare src_ready and the output record on every cycle of each sequence.

// File: rtl/rc_pkg.sv
package rc_pkg;
  parameter int unsigned RC_ROB_W = 6;
  parameter int unsigned RC_REG_W = 5;
  parameter int unsigned RC_VAL_W = 32;

  typedef struct packed {
    logic [RC_ROB_W-1:0] rob_id;
    logic [RC_REG_W-1:0] rp_dst;
    logic [RC_VAL_W-1:0] value;
    logic                exception;
  } rc_rec_t;

  localparam int unsigned RC_REC_W = $bits(rc_rec_t);
endpackage

// File: rtl/rc_rr_pick.sv
// Rotating first-set finder: returns the first request at or after ptr.
module rc_rr_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] ptr,
  output logic [N-1:0]     gnt_oh,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             any
);
  always_comb begin
    gnt_oh  = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int off = 0; off < int'(N); off++) begin
      if (!any && req[(int'(ptr) + off) % int'(N)]) begin
        any = 1'b1;
        gnt_oh[(int'(ptr) + off) % int'(N)] = 1'b1;
        gnt_idx = IDX_W'((int'(ptr) + off) % int'(N));
      end
    end
  end
endmodule

// File: rtl/rc_rr_arb.sv
// Two-deep round-robin arbiter: picks a first and a second winner per cycle.
module rc_rr_arb #(
  parameter int unsigned N = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             adv,
  input  logic [IDX_W-1:0] adv_idx,
  output logic [N-1:0]     first_oh,
  output logic [IDX_W-1:0] first_idx,
  output logic             first_any,
  output logic [N-1:0]     second_oh,
  output logic [IDX_W-1:0] second_idx,
  output logic             second_any
);
  logic [IDX_W-1:0] ptr_q;
  logic [N-1:0]     rest_req;

  assign rest_req = req & ~first_oh;

  rc_rr_pick #(.N(N)) pick_first_i (
    .req(req), .ptr(ptr_q), .gnt_oh(first_oh), .gnt_idx(first_idx), .any(first_any)
  );

  rc_rr_pick #(.N(N)) pick_second_i (
    .req(rest_req), .ptr(ptr_q), .gnt_oh(second_oh), .gnt_idx(second_idx), .any(second_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv) begin
      if (int'(adv_idx) == int'(N) - 1) ptr_q <= '0;
      else                              ptr_q <= adv_idx + 1'b1;
    end
  end
endmodule

// File: rtl/rc_fwd_slot.sv
// One-entry forwarding register on the output data path.
module rc_fwd_slot
  import rc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  rc_rec_t load_rec,
  input  logic    drain,
  output logic    full,
  output rc_rec_t rec
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      rec  <= '0;
    end else begin
      if (load) begin
        full <= 1'b1;
        rec  <= load_rec;
      end else if (drain) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/result_collector.sv
module result_collector
  import rc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_SRC-1:0]                 src_valid,
  output logic [NUM_SRC-1:0]                 src_ready,
  input  logic [NUM_SRC-1:0][RC_ROB_W-1:0]   src_rob_id,
  input  logic [NUM_SRC-1:0][RC_REG_W-1:0]   src_rp_dst,
  input  logic [NUM_SRC-1:0][RC_VAL_W-1:0]   src_value,
  input  logic [NUM_SRC-1:0]                 src_exception,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [RC_ROB_W-1:0]                out_rob_id,
  output logic [RC_REG_W-1:0]                out_rp_dst,
  output logic [RC_VAL_W-1:0]                out_value,
  output logic                               out_exception
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  rc_rec_t src_rec [NUM_SRC];

  for (genvar gi = 0; gi < int'(NUM_SRC); gi++) begin : g_rec
    assign src_rec[gi] = '{rob_id:    src_rob_id[gi],
                           rp_dst:    src_rp_dst[gi],
                           value:     src_value[gi],
                           exception: src_exception[gi]};
  end

  logic [NUM_SRC-1:0] first_oh, second_oh;
  logic [IDX_W-1:0]   first_idx, second_idx;
  logic               first_any, second_any;
  logic               grant1, grant2;
  logic               fwd_full, fwd_load, fwd_drain;
  rc_rec_t            fwd_rec, direct_rec, load_rec, out_rec;

  rc_rr_arb #(.N(NUM_SRC)) arb_i (
    .clk(clk), .rst_n(rst_n), .req(src_valid),
    .adv(grant1), .adv_idx(grant2 ? second_idx : first_idx),
    .first_oh(first_oh), .first_idx(first_idx), .first_any(first_any),
    .second_oh(second_oh), .second_idx(second_idx), .second_any(second_any)
  );

  // A held entry always leaves before fresh sources are taken.
  assign grant1 = ~fwd_full & first_any;
  // A second winner can only be parked when the first leaves directly.
  assign grant2 = grant1 & out_ready & second_any;

  assign src_ready = ({NUM_SRC{grant1}} & first_oh) | ({NUM_SRC{grant2}} & second_oh);

  assign direct_rec = src_rec[first_idx];
  assign out_rec    = fwd_full ? fwd_rec : direct_rec;
  assign out_valid  = fwd_full | first_any;

  assign fwd_load  = grant1 & (~out_ready | grant2);
  assign load_rec  = out_ready ? src_rec[second_idx] : direct_rec;
  assign fwd_drain = fwd_full & out_ready;

  rc_fwd_slot fwd_i (
    .clk(clk), .rst_n(rst_n), .load(fwd_load), .load_rec(load_rec),
    .drain(fwd_drain), .full(fwd_full), .rec(fwd_rec)
  );

  assign out_rob_id    = out_rec.rob_id;
  assign out_rp_dst    = out_rec.rp_dst;
  assign out_value     = out_rec.value;
  assign out_exception = out_rec.exception;
endmodule

// File: rtl/result_collector_chk.sv
module result_collector_chk
  import rc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_SRC-1:0]  src_valid,
  input logic [NUM_SRC-1:0]  src_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [RC_ROB_W-1:0] out_rob_id,
  input logic [RC_REG_W-1:0] out_rp_dst,
  input logic [RC_VAL_W-1:0] out_value,
  input logic                out_exception,
  input logic                fwd_full
);
  p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready & ~src_valid) == '0);

  p_two_grants_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_ready) <= 2);

  p_full_blocks_grants_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_full |-> src_ready == '0);

  p_out_valid_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (fwd_full || (src_valid != '0)));

  p_single_grant_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> $countones(src_ready) <= 1);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rob_id) && $stable(out_rp_dst)
                                   && $stable(out_value) && $stable(out_exception)));

  p_double_grant_parks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(src_ready) == 2) |=> (fwd_full && out_valid));
endmodule

bind result_collector result_collector_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_rob_id(out_rob_id),
  .out_rp_dst(out_rp_dst), .out_value(out_value), .out_exception(out_exception),
  .fwd_full(fwd_full)
);

// File: tb/result_collector_tb_top.sv
module result_collector_tb_top;
  import rc_pkg::*;
  localparam int unsigned N = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_valid = '0;
  logic [N-1:0] src_ready;
  logic [N-1:0][RC_ROB_W-1:0] src_rob_id = '0;
  logic [N-1:0][RC_REG_W-1:0] src_rp_dst = '0;
  logic [N-1:0][RC_VAL_W-1:0] src_value = '0;
  logic [N-1:0] src_exception = '0;
  logic out_valid, out_ready = 1'b0;
  logic [RC_ROB_W-1:0] out_rob_id;
  logic [RC_REG_W-1:0] out_rp_dst;
  logic [RC_VAL_W-1:0] out_value;
  logic out_exception;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  result_collector #(.NUM_SRC(N)) dut_i (.*);

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Record tag for source i, generation g.
  task automatic load_src(int i, int g, bit exc);
    src_rob_id[i]    = RC_ROB_W'(i * 8 + g);
    src_rp_dst[i]    = RC_REG_W'(i + 1 + g);
    src_value[i]     = RC_VAL_W'(32'hA000_0000 + i * 16 + g);
    src_exception[i] = exc;
  endtask

  task automatic check_out(string req, int i, int g, bit exc);
    check({req, " valid"}, out_valid, 1);
    check({req, " rob"}, out_rob_id, RC_ROB_W'(i * 8 + g));
    check({req, " dst"}, out_rp_dst, RC_REG_W'(i + 1 + g));
    check({req, " val"}, out_value, RC_VAL_W'(32'hA000_0000 + i * 16 + g));
    check({req, " exc"}, out_exception, exc);
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    src_valid = '0;
    out_ready = 1'b0;
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 src_ready", src_ready, 0);
  endtask

  task automatic t_single();
    do_reset();
    load_src(2, 1, 1'b1);
    src_valid = 4'b0100;
    out_ready = 1'b1;
    #1;
    check("R4 grant", src_ready, 4'b0100);
    check_out("R3", 2, 1, 1'b1);
    step();
    src_valid = '0;
    #1;
    check("R2 idle after direct", out_valid, 0);
  endtask

  task automatic t_pair();
    do_reset();
    load_src(0, 2, 1'b0);
    load_src(1, 3, 1'b0);
    src_valid = 4'b0011;
    out_ready = 1'b1;
    #1;
    check("R5 two grants", src_ready, 4'b0011);
    check_out("R5 direct", 0, 2, 1'b0);
    step();
    load_src(3, 4, 1'b1);
    src_valid = 4'b1000;
    #1;
    check("R6 no grant while full", src_ready, 0);
    check_out("R5 parked", 1, 3, 1'b0);
    step();
    #1;
    check("R6 grant after drain", src_ready, 4'b1000);
    check_out("R6 fresh", 3, 4, 1'b1);
    step();
    src_valid = '0;
    #1;
    check("R2 idle", out_valid, 0);
  endtask

  task automatic t_stall();
    do_reset();
    load_src(1, 5, 1'b0);
    load_src(2, 6, 1'b0);
    src_valid = 4'b0110;
    out_ready = 1'b0;
    #1;
    check("R7 one grant", src_ready, 4'b0010);
    check_out("R7 offered", 1, 5, 1'b0);
    step();
    src_valid = 4'b0100;
    #1;
    check("R7 blocked", src_ready, 0);
    check_out("R7 held", 1, 5, 1'b0);
    out_ready = 1'b1;
    #1;
    check("R6 drain first", src_ready, 0);
    step();
    #1;
    check("R8 next after 1", src_ready, 4'b0100);
    check_out("R3 src2", 2, 6, 1'b0);
    step();
    src_valid = '0;
  endtask

  task automatic t_rr();
    do_reset();
    for (int i = 0; i < 4; i++) load_src(i, 0, 1'b0);
    src_valid = 4'b1111;
    out_ready = 1'b1;
    #1;
    check("R8 first pair", src_ready, 4'b0011);
    check_out("R8 src0", 0, 0, 1'b0);
    step();
    for (int i = 0; i < 2; i++) load_src(i, 1, 1'b0);
    #1;
    check_out("R8 parked src1", 1, 0, 1'b0);
    step();
    #1;
    check("R8 second pair", src_ready, 4'b1100);
    check_out("R8 src2", 2, 0, 1'b0);
    step();
    src_valid = 4'b0011;
    #1;
    check_out("R8 parked src3", 3, 0, 1'b0);
    step();
    #1;
    check("R8 wrap", src_ready, 4'b0011);
    check_out("R8 src0 again", 0, 1, 1'b0);
    step();
    src_valid = 4'b0101;
    load_src(0, 2, 1'b0);
    load_src(2, 2, 1'b0);
    #1;
    check_out("R8 parked src1 again", 1, 1, 1'b0);
    step();
    #1;
    check("R8 start at 2", src_ready, 4'b0101);
    check_out("R8 src2 leads", 2, 2, 1'b0);
    step();
    src_valid = '0;
  endtask

  initial begin
    t_reset();
    t_single();
    t_pair();
    t_stall();
    t_rr();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule